// File: doc/BRIEF.md
# Display Row Address Generator with Split-Screen

This block produces, for every displayed scanline, the frame-buffer address at which the line's data begins. It also produces the row-within-character count and a running count of lines. It sits beside the display timing generator, which gives it a frame-start strobe at the top of each frame and a line-end strobe at the end of each horizontal line. The address advances by one programmed row pitch each time a character row of the programmed height ends.

Software sets the block up through an indexed register pair. The index is written first, and then the data port writes or reads the selected byte. Programmed values are staged and copied into the working set only when a frame begins, so a frame never changes geometry partway through. A programmed compare line makes the address snap back to zero partway down the frame. Everything below that line then shows the start of the frame buffer, which gives a split screen. A double-scan option makes the row count advance on every second line only, so each source line is drawn twice.

Top module: `row_addr_gen`

## Requirements
- R1: After reset, `line_addr`, `row_scan` and `vline` are 0, and every register reads back as 0.
- R2: Asserting `idx_wr` captures `wr_data` as the index. Asserting `dat_wr` stores `wr_data` into the register that index selects, and `rd_data` always shows the stored byte of the selected register. The defined indices are:
  - 09h: bit 7 is double-scan enable, bit 6 is compare bit 9, bit 5 is a stored-only vertical-blank bit 9, and bits 4..0 are the row height minus one.
  - 07h: bit 4 is compare bit 8.
  - 0Ch and 0Dh: start address high byte and low byte.
  - 13h: row pitch in words.
  - 18h: compare bits 7..0.
  - Any other index ignores writes and reads as 0.
- R3: Register writes change no output until the next `frame_start`. From that point the new values apply for the whole frame.
- R4: The cycle after `frame_start`, `vline` and `row_scan` are 0 and `line_addr` equals the 16-bit start address. `frame_start` wins over a simultaneous `line_end`.
- R5: Each `line_end` without `frame_start` increments the 10-bit `vline` by 1.
- R6: With double scan off, `row_scan` advances on every `line_end`. When it is at the programmed maximum it wraps to 0, and `line_addr` then grows by twice the row pitch (the pitch is in 2-byte words). `line_addr` holds at all other times.
- R7: With double scan on, `row_scan` and `line_addr` advance only on every second `line_end` after the frame start or after a split, so each row value lasts two lines.
- R8: When the incremented line count equals the 10-bit compare value, `line_addr` and `row_scan` become 0. The double-scan pairing also restarts, and the address then advances normally from 0.
- R9: A compare value beyond the last line driven in the frame causes no split.
- R10: A compare value of 0 makes `frame_start` load `line_addr` with 0 instead of the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Top-of-frame strobe, one cycle |
| line_end | input | 1 | End-of-line strobe, one cycle |
| idx_wr | input | 1 | Load `wr_data` into the index register |
| dat_wr | input | 1 | Write `wr_data` to the indexed register |
| wr_data | input | 8 | Index or data byte |
| rd_data | output | 8 | Stored byte of the indexed register |
| line_addr | output | AW | Frame-buffer address of the current line |
| row_scan | output | 5 | Line number within the character row |
| vline | output | LW | Line count since frame start |

## Verification
Compare values are placed so that bits 8 and 9 each decide the split line. A design that dropped either upper bit would split hundreds of lines too early. The bench checks the line just before and just after each split, which exposes off-by-one compares against the old count versus the new count. Double-scan runs check that each row value lasts exactly two lines; a design that ignored the pairing would show the pitch growth at twice the rate. Mid-frame writes are checked against unchanged outputs, which catches registers that bypass the staged copy. Simultaneous strobes and a zero compare value are also tested, since they decide whether the frame's first line starts from the start address, from zero, or from a half-advanced count.

// File: rtl/rag_pkg.sv
package rag_pkg;
   localparam logic [7:0] IX_OVFL = 8'h07;
   localparam logic [7:0] IX_SCAN = 8'h09;
   localparam logic [7:0] IX_STH  = 8'h0C;
   localparam logic [7:0] IX_STL  = 8'h0D;
   localparam logic [7:0] IX_PITCH = 8'h13;
   localparam logic [7:0] IX_LCMP = 8'h18;

   localparam int CMP_W = 10;
   localparam int ROW_W = 5;

   // working copy captured at frame start
   typedef struct packed {
      logic              dbl;
      logic [CMP_W-1:0]  lcmp;
      logic [ROW_W-1:0]  max_row;
      logic [7:0]        pitch;
   } act_cfg_t;
endpackage

// File: rtl/rag_regs.sv
module rag_regs
   import rag_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              idx_wr,
   input  logic              dat_wr,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data,
   output logic [15:0]       stg_start,
   output logic [CMP_W-1:0]  stg_lcmp,
   output act_cfg_t          act
);
   logic [7:0] idx_q, ovfl_q, scan_q, sth_q, stl_q, pitch_q, lcmp_q;
   act_cfg_t   stg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q   <= '0;
         ovfl_q  <= '0;
         scan_q  <= '0;
         sth_q   <= '0;
         stl_q   <= '0;
         pitch_q <= '0;
         lcmp_q  <= '0;
      end else begin
         if (idx_wr) idx_q <= wr_data;
         if (dat_wr) begin
            unique case (idx_q)
               IX_OVFL:  ovfl_q  <= wr_data;
               IX_SCAN:  scan_q  <= wr_data;
               IX_STH:   sth_q   <= wr_data;
               IX_STL:   stl_q   <= wr_data;
               IX_PITCH: pitch_q <= wr_data;
               IX_LCMP:  lcmp_q  <= wr_data;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (idx_q)
         IX_OVFL:  rd_data = ovfl_q;
         IX_SCAN:  rd_data = scan_q;
         IX_STH:   rd_data = sth_q;
         IX_STL:   rd_data = stl_q;
         IX_PITCH: rd_data = pitch_q;
         IX_LCMP:  rd_data = lcmp_q;
         default:  rd_data = 8'h00;
      endcase
   end

   always_comb begin
      stg.dbl     = scan_q[7];
      stg.lcmp    = {scan_q[6], ovfl_q[4], lcmp_q};
      stg.max_row = scan_q[ROW_W-1:0];
      stg.pitch   = pitch_q;
   end

   assign stg_start = {sth_q, stl_q};
   assign stg_lcmp  = stg.lcmp;

   always_ff @(posedge clk) begin
      if (!rst_n)           act <= '0;
      else if (frame_start) act <= stg;
   end

   // R3
   hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(act));
endmodule

// File: rtl/rag_line_seq.sv
module rag_line_seq
   import rag_pkg::*;
#(
   parameter int LW = 10
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              line_end,
   input  logic              dbl,
   input  logic [CMP_W-1:0]  lcmp,
   input  logic [ROW_W-1:0]  max_row,
   output logic [LW-1:0]     vline,
   output logic [ROW_W-1:0]  row_scan,
   output logic              split_hit,
   output logic              row_adv
);
   logic [LW-1:0] vnext;
   logic          phase_q, hold, step, adv_line;

   assign adv_line  = line_end & ~frame_start;
   assign vnext     = vline + 1'b1;
   assign split_hit = adv_line & (vnext == LW'(lcmp));
   assign hold      = dbl & ~phase_q;
   assign step      = adv_line & ~split_hit & ~hold;
   assign row_adv   = step & (row_scan == max_row);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vline    <= '0;
         row_scan <= '0;
         phase_q  <= 1'b0;
      end else if (frame_start) begin
         vline    <= '0;
         row_scan <= '0;
         phase_q  <= 1'b0;
      end else if (line_end) begin
         vline <= vnext;
         if (split_hit) begin
            row_scan <= '0;
            phase_q  <= 1'b0;
         end else begin
            phase_q <= ~phase_q;
            if (step) row_scan <= row_adv ? '0 : row_scan + 1'b1;
         end
      end
   end

   // R4
   frame_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (vline == '0) && (row_scan == '0));
   // R5
   vline_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv_line |=> vline == LW'($past(vline) + 1'b1));
   // R6
   row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_scan <= max_row);
   // R7
   dbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbl && adv_line && !split_hit && !phase_q) |=> $stable(row_scan));
endmodule

// File: rtl/rag_addr_gen.sv
module rag_addr_gen
   import rag_pkg::*;
#(
   parameter int AW = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              split_hit,
   input  logic              row_adv,
   input  logic [15:0]       stg_start,
   input  logic [CMP_W-1:0]  stg_lcmp,
   input  logic [7:0]        pitch,
   output logic [AW-1:0]     line_addr
);
   localparam int PW = 9;
   logic [AW-1:0] step_bytes;

   assign step_bytes = AW'({pitch, 1'b0});

   always_ff @(posedge clk) begin
      if (!rst_n)             line_addr <= '0;
      else if (frame_start)   line_addr <= (stg_lcmp == '0) ? '0 : AW'(stg_start);
      else if (split_hit)     line_addr <= '0;
      else if (row_adv)       line_addr <= line_addr + step_bytes;
   end

   // R8
   split_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (split_hit && !frame_start) |=> line_addr == '0);
   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_start && !split_hit && !row_adv) |=> $stable(line_addr));

   initial begin
      if (AW < PW) $error("address width too narrow for row pitch");
   end
endmodule

// File: rtl/row_addr_gen.sv
module row_addr_gen
   import rag_pkg::*;
#(
   parameter int AW = 16,
   parameter int LW = 10
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_start,
   input  logic          line_end,
   input  logic          idx_wr,
   input  logic          dat_wr,
   input  logic [7:0]    wr_data,
   output logic [7:0]    rd_data,
   output logic [AW-1:0] line_addr,
   output logic [4:0]    row_scan,
   output logic [LW-1:0] vline
);
   generate
      if (AW < 16) begin : g_bad_aw
         $error("AW must hold the 16-bit start address");
      end
      if (LW < CMP_W) begin : g_bad_lw
         $error("LW must hold the 10-bit compare value");
      end
   endgenerate

   logic [15:0]      stg_start;
   logic [CMP_W-1:0] stg_lcmp;
   act_cfg_t         act;
   logic             split_hit, row_adv;

   rag_regs u_regs (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .idx_wr(idx_wr), .dat_wr(dat_wr), .wr_data(wr_data), .rd_data(rd_data),
      .stg_start(stg_start), .stg_lcmp(stg_lcmp), .act(act)
   );

   rag_line_seq #(.LW(LW)) u_seq (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_end(line_end),
      .dbl(act.dbl), .lcmp(act.lcmp), .max_row(act.max_row),
      .vline(vline), .row_scan(row_scan), .split_hit(split_hit), .row_adv(row_adv)
   );

   rag_addr_gen #(.AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .split_hit(split_hit), .row_adv(row_adv),
      .stg_start(stg_start), .stg_lcmp(stg_lcmp), .pitch(act.pitch),
      .line_addr(line_addr)
   );
endmodule

// File: tb/sim_row_addr_gen.sv
module sim_row_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0, line_end = 1'b0, idx_wr = 1'b0, dat_wr = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic [15:0] line_addr;
   logic [4:0]  row_scan;
   logic [9:0]  vline;
   int errors = 0, checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   row_addr_gen u0 (.clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_end(line_end),
      .idx_wr(idx_wr), .dat_wr(dat_wr), .wr_data(wr_data), .rd_data(rd_data),
      .line_addr(line_addr), .row_scan(row_scan), .vline(vline));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] ix, input logic [7:0] val);
      @(negedge clk); idx_wr = 1'b1; wr_data = ix;
      @(negedge clk); idx_wr = 1'b0; dat_wr = 1'b1; wr_data = val;
      @(negedge clk); dat_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] ix, output logic [7:0] val);
      @(negedge clk); idx_wr = 1'b1; wr_data = ix;
      @(negedge clk); idx_wr = 1'b0; val = rd_data;
   endtask

   task automatic cfg(input bit dbl, input logic [4:0] mx, input logic [15:0] st,
                      input logic [7:0] pit, input logic [9:0] lc);
      wr_reg(8'h09, {dbl, lc[9], 1'b0, mx});
      wr_reg(8'h07, {3'b000, lc[8], 4'h0});
      wr_reg(8'h0C, st[15:8]);
      wr_reg(8'h0D, st[7:0]);
      wr_reg(8'h13, pit);
      wr_reg(8'h18, lc[7:0]);
   endtask

   task automatic pulse_frame();
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
   endtask

   task automatic pulse_lines(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); line_end = 1'b1;
         @(negedge clk); line_end = 1'b0;
      end
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R1 addr", line_addr, 0);
      check("R1 row", row_scan, 0);
      check("R1 vline", vline, 0);
      rd_reg(8'h09, v); check("R1 reg09", v, 0);
   endtask

   task automatic t_regs();
      logic [7:0] v;
      wr_reg(8'h09, 8'hA5); rd_reg(8'h09, v); check("R2 09h", v, 8'hA5);
      wr_reg(8'h07, 8'h10); rd_reg(8'h07, v); check("R2 07h", v, 8'h10);
      wr_reg(8'h0C, 8'h12); rd_reg(8'h0C, v); check("R2 0Ch", v, 8'h12);
      wr_reg(8'h0D, 8'h34); rd_reg(8'h0D, v); check("R2 0Dh", v, 8'h34);
      wr_reg(8'h13, 8'h28); rd_reg(8'h13, v); check("R2 13h", v, 8'h28);
      wr_reg(8'h18, 8'h77); rd_reg(8'h18, v); check("R2 18h", v, 8'h77);
      wr_reg(8'h55, 8'hFF); rd_reg(8'h55, v); check("R2 unknown index", v, 0);
      rd_reg(8'h09, v); check("R2 09h unaliased", v, 8'hA5);
   endtask

   task automatic t_defer();
      cfg(0, 5'd3, 16'h1234, 8'h28, 10'h3FF);
      pulse_lines(4);
      check("R3 addr before frame", line_addr, 0);
      check("R3 row before frame", row_scan, 0);
      check("R5 vline count", vline, 4);
      pulse_frame();
      check("R3 start applied", line_addr, 16'h1234);
      wr_reg(8'h0C, 8'h56); wr_reg(8'h0D, 8'h78);
      pulse_lines(4);
      check("R3 mid-frame write ignored", line_addr, 16'h1234 + 80);
      pulse_frame();
      check("R3 new start at next frame", line_addr, 16'h5678);
   endtask

   task automatic t_single();
      cfg(0, 5'd3, 16'h0100, 8'h28, 10'h3FF);
      pulse_frame();
      check("R4 addr", line_addr, 16'h0100);
      for (int n = 1; n <= 12; n++) begin
         pulse_lines(1);
         check("R6 row", row_scan, n % 4);
         check("R6 addr", line_addr, 16'h0100 + (n / 4) * 80);
         check("R5 vline", vline, n);
      end
   endtask

   task automatic t_double();
      cfg(1, 5'd1, 16'h0200, 8'h10, 10'h3FF);
      pulse_frame();
      for (int n = 1; n <= 12; n++) begin
         pulse_lines(1);
         check("R7 row", row_scan, (n / 2) % 2);
         check("R7 addr", line_addr, 16'h0200 + (n / 4) * 32);
      end
   endtask

   task automatic t_split8();
      cfg(0, 5'd7, 16'h0800, 8'h10, 10'h105);
      pulse_frame();
      pulse_lines(260);
      check("R8 row before split", row_scan, 4);
      check("R8 addr before split", line_addr, 16'h0C00);
      pulse_lines(1);
      check("R8 vline at split", vline, 261);
      check("R8 addr zero", line_addr, 0);
      check("R8 row zero", row_scan, 0);
      pulse_lines(9);
      check("R8 row after split", row_scan, 1);
      check("R8 addr after split", line_addr, 32);
   endtask

   task automatic t_split9();
      cfg(0, 5'd0, 16'h0400, 8'h01, 10'h203);
      pulse_frame();
      pulse_lines(514);
      check("R8 bit9 before split", line_addr, 16'h0804);
      pulse_lines(1);
      check("R8 bit9 split", line_addr, 0);
      pulse_lines(1);
      check("R8 bit9 after split", line_addr, 2);
   endtask

   task automatic t_nosplit();
      int zero_seen = 0;
      cfg(0, 5'd1, 16'h0300, 8'h08, 10'h3FF);
      pulse_frame();
      for (int n = 1; n <= 300; n++) begin
         pulse_lines(1);
         if (line_addr == 0) zero_seen++;
      end
      check("R9 never zero", zero_seen, 0);
      check("R9 final addr", line_addr, 16'h0C60);
   endtask

   task automatic t_lc0();
      cfg(0, 5'd3, 16'h1111, 8'h04, 10'h000);
      pulse_frame();
      check("R10 addr at frame", line_addr, 0);
      pulse_lines(4);
      check("R10 addr after row", line_addr, 8);
   endtask

   task automatic t_prio();
      cfg(0, 5'd3, 16'h0A00, 8'h28, 10'h3FF);
      pulse_frame();
      pulse_lines(5);
      @(negedge clk); frame_start = 1'b1; line_end = 1'b1;
      @(negedge clk); frame_start = 1'b0; line_end = 1'b0;
      check("R4 prio vline", vline, 0);
      check("R4 prio row", row_scan, 0);
      check("R4 prio addr", line_addr, 16'h0A00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_defer();
      t_single();
      t_double();
      t_split8();
      t_split9();
      t_nosplit();
      t_lc0();
      t_prio();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule